// File: doc/BRIEF.md
# IR Wake Pattern Matcher

This block watches a demodulated infrared stream, delivered as one cell (or bit) per qualifying clock, and decides whether the most recent run of cells equals a reference pattern stored in registers. Each stored pattern bit carries its own mask bit, so fields that legitimately change between presses of a remote button, such as a toggle bit, can be excluded from the comparison. When the comparison succeeds under the programmed length rule, a sticky flag is set and, if enabled, a registered wake line is raised toward the power controller.

Software reaches the block through a small byte-wide register port. An index register picks one of two 88-bit banks (reference or mask) and a starting byte. Successive writes to a single data port then fill that bank byte by byte. A compare-length register requires an exact number of received cells before a comparison is accepted. A status register collects sticky flags for match, end of message, a full 88-cell buffer, and an externally detected repeat code. An event-enable register picks which of the first three flags may wake the system.

Top module: `irwake_matcher`

## Requirements
- R1: After reset every readable register (control, status, event enable, index, compare length) reads 0 and `wake` is 0.
- R2: Register offsets on `reg_addr` are: 0 control (bit 0 = global enable), 1 status, 2 event enable (bits 2:0), 3 index, 4 data port, 5 compare length. `reg_rdata` shows the register addressed in one cycle at the next clock edge.
- R3: Index bits 5:4 choose the bank (01 = reference, 10 = mask) and bits 3:0 give the byte address. A data-port write stores into the selected bank at that address. The address then advances by one and wraps from 10 to 0. A read of the data port returns the selected byte without advancing.
- R4: A data-port write with bank code 00 or 11 changes neither bank, but the address still advances.
- R5: Each accepted cell (`cell_valid`) shifts into bit 0 of an 88-bit register. `msg_start` clears the register and the cell count, and it wins over a `cell_valid` in the same cycle, which is then dropped.
- R6: Reference byte i bit j is compared with shift bit 8*i+j. A mask bit of 1 requires equality and a mask bit of 0 ignores that bit.
- R7: With compare length 0, a comparison counts after any accepted cell. Otherwise it counts only when the cell count since `msg_start` equals the compare length exactly. The count saturates at 255.
- R8: Status bit 0 (match) sets on the clock edge after the edge that accepted the completing cell. `wake` follows one edge later.
- R9: Status bits 0, 1, 2 and 4 are sticky and cleared by writing 1. Writing 0 has no effect. A flag being set wins over its clear in the same cycle.
- R10: `msg_end` sets status bit 1, the 88th cell accepted since `msg_start` sets status bit 2, and `rpt_seen` sets status bit 4.
- R11: `wake` is 1 exactly when the global enable is set and some status bit among 2:0 is set with its event-enable bit of the same position. Status bit 4 never wakes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data |
| cell_valid | input | 1 | A received cell is present this cycle |
| cell_bit | input | 1 | Value of the received cell |
| msg_start | input | 1 | Start-of-message strobe, clears the shift register and count |
| msg_end | input | 1 | End-of-message strobe from the front end |
| rpt_seen | input | 1 | Repeat-code strobe from an external decoder |
| wake | output | 1 | Registered wake request |

## Verification
A status flag can be set by an event in the same cycle that software writes 1 to clear it. The bench provokes this by raising `msg_end` on the very clock on which a write of 1 to bit 1 of the status register lands, and also repeats the case with `rpt_seen`. It judges the result by reading the status afterwards and requiring the flag to remain set, then clearing it with a lone write. The matching itself is swept over all 40 single-cell corruptions of an encoded frame and over several compare lengths, each compared against a bench model of the masked shift register.

// File: rtl/irwake_pkg.sv
package irwake_pkg;
  localparam int unsigned LEN_W = 8;          // cell counter and compare-length width
  localparam logic [7:0]  STS_MASK = 8'h17;   // implemented sticky flags

  typedef enum logic [2:0] {
    RA_CTRL  = 3'd0,
    RA_STAT  = 3'd1,
    RA_EVEN  = 3'd2,
    RA_INDEX = 3'd3,
    RA_DATA  = 3'd4,
    RA_CLEN  = 3'd5
  } reg_addr_e;

  typedef enum logic [1:0] {
    BK_NONE = 2'b00,
    BK_CMP  = 2'b01,
    BK_MSK  = 2'b10,
    BK_RSV  = 2'b11
  } bank_e;
endpackage

// File: rtl/irwake_regfile.sv
module irwake_regfile
  import irwake_pkg::*;
#(
  parameter int unsigned PAT_BYTES = 11,
  localparam int unsigned PAT_BITS = PAT_BYTES * 8,
  localparam int unsigned AW       = $clog2(PAT_BYTES)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                we,
  input  logic [2:0]          addr,
  input  logic [7:0]          wdata,
  input  logic [7:0]          sts_i,
  output logic [7:0]          rdata,
  output logic                ctl_en_o,
  output logic [2:0]          ev_en_o,
  output logic [LEN_W-1:0]    clen_o,
  output logic [PAT_BITS-1:0] cmp_o,
  output logic [PAT_BITS-1:0] msk_o
);
  logic                      ctl_q;
  logic [2:0]                even_q;
  bank_e                     bank_q;
  logic [AW-1:0]             ptr_q;
  logic [LEN_W-1:0]          clen_q;
  logic [PAT_BYTES-1:0][7:0] cmp_q;
  logic [PAT_BYTES-1:0][7:0] msk_q;

  logic          wr_data;
  logic          ptr_ok;
  logic [AW-1:0] ptr_nx;
  logic [7:0]    idx_rd;
  logic [7:0]    sel_byte;

  assign wr_data = we && (addr == RA_DATA);
  assign ptr_ok  = (ptr_q < AW'(PAT_BYTES));
  assign ptr_nx  = (ptr_q >= AW'(PAT_BYTES - 1)) ? '0 : ptr_q + AW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q  <= 1'b0;
      even_q <= '0;
      bank_q <= BK_NONE;
      ptr_q  <= '0;
      clen_q <= '0;
    end else if (we) begin
      case (addr)
        RA_CTRL:  ctl_q  <= wdata[0];
        RA_EVEN:  even_q <= wdata[2:0];
        RA_INDEX: begin
          bank_q <= bank_e'(wdata[AW+1:AW]);
          ptr_q  <= wdata[AW-1:0];
        end
        RA_DATA:  ptr_q  <= ptr_nx;
        RA_CLEN:  clen_q <= wdata;
        default:  ;
      endcase
    end
  end

  // One byte lane per pattern byte for each bank.
  for (genvar i = 0; i < PAT_BYTES; i++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) begin
        cmp_q[i] <= '0;
        msk_q[i] <= '0;
      end else if (wr_data && ptr_q == AW'(i)) begin
        if (bank_q == BK_CMP) cmp_q[i] <= wdata;
        if (bank_q == BK_MSK) msk_q[i] <= wdata;
      end
    end
  end

  always_comb begin
    idx_rd            = '0;
    idx_rd[AW+1:AW]   = bank_q;
    idx_rd[AW-1:0]    = ptr_q;
    sel_byte          = '0;
    if (ptr_ok) begin
      if (bank_q == BK_CMP) sel_byte = cmp_q[ptr_q];
      if (bank_q == BK_MSK) sel_byte = msk_q[ptr_q];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      case (addr)
        RA_CTRL:  rdata <= {7'b0, ctl_q};
        RA_STAT:  rdata <= sts_i;
        RA_EVEN:  rdata <= {5'b0, even_q};
        RA_INDEX: rdata <= idx_rd;
        RA_DATA:  rdata <= sel_byte;
        RA_CLEN:  rdata <= clen_q;
        default:  rdata <= '0;
      endcase
    end
  end

  assign ctl_en_o = ctl_q;
  assign ev_en_o  = even_q;
  assign clen_o   = clen_q;
  assign cmp_o    = cmp_q;
  assign msk_o    = msk_q;

  // R3: the byte address advances and wraps after every data-port write
  a_r3_ptr_adv: assert property (@(posedge clk) disable iff (rst)
    wr_data |=> ptr_q == (($past(ptr_q) >= AW'(PAT_BYTES - 1)) ? '0 : $past(ptr_q) + AW'(1)));

  // R4: writes with no valid bank leave both banks untouched
  a_r4_bank_hold: assert property (@(posedge clk) disable iff (rst)
    (wr_data && bank_q != BK_CMP && bank_q != BK_MSK) |=> ($stable(cmp_q) && $stable(msk_q)));
endmodule

// File: rtl/irwake_shifter.sv
module irwake_shifter
  import irwake_pkg::*;
#(
  parameter int unsigned PAT_BITS = 88,
  localparam logic [LEN_W-1:0] CNT_MAX = '1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cell_valid,
  input  logic                cell_bit,
  input  logic                msg_start,
  output logic [PAT_BITS-1:0] shreg_o,
  output logic [LEN_W-1:0]    cnt_o,
  output logic                upd_o,
  output logic                full_o
);
  logic [PAT_BITS-1:0] sh_q;
  logic [LEN_W-1:0]    cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      upd_o  <= 1'b0;
      full_o <= 1'b0;
    end else begin
      upd_o  <= 1'b0;
      full_o <= 1'b0;
      if (msg_start) begin
        sh_q  <= '0;
        cnt_q <= '0;
      end else if (cell_valid) begin
        sh_q   <= {sh_q[PAT_BITS-2:0], cell_bit};
        cnt_q  <= (cnt_q == CNT_MAX) ? cnt_q : cnt_q + LEN_W'(1);
        upd_o  <= 1'b1;
        full_o <= (cnt_q == LEN_W'(PAT_BITS - 1));
      end
    end
  end

  assign shreg_o = sh_q;
  assign cnt_o   = cnt_q;

  // R5: start of message empties the register and the count
  a_r5_clear: assert property (@(posedge clk) disable iff (rst)
    msg_start |=> (cnt_q == '0 && sh_q == '0 && !upd_o));

  // R5: a new cell lands in bit 0 and older cells move up by one
  a_r5_shift: assert property (@(posedge clk) disable iff (rst)
    (cell_valid && !msg_start) |=>
      (sh_q[0] == $past(cell_bit) && sh_q[PAT_BITS-1:1] == $past(sh_q[PAT_BITS-2:0])));

  // R7: the count only falls through a start of message
  a_r7_cnt_mono: assert property (@(posedge clk) disable iff (rst)
    !msg_start |=> cnt_q >= $past(cnt_q));
endmodule

// File: rtl/irwake_compare.sv
module irwake_compare
  import irwake_pkg::*;
#(
  parameter int unsigned PAT_BYTES = 11,
  localparam int unsigned PAT_BITS = PAT_BYTES * 8
) (
  input  logic [PAT_BITS-1:0] shreg,
  input  logic [PAT_BITS-1:0] cmp,
  input  logic [PAT_BITS-1:0] msk,
  input  logic [LEN_W-1:0]    cnt,
  input  logic [LEN_W-1:0]    clen,
  input  logic                upd,
  output logic                hit
);
  logic [PAT_BYTES-1:0] byte_ok;
  logic                 gate;

  for (genvar i = 0; i < PAT_BYTES; i++) begin : g_byte
    assign byte_ok[i] = ((shreg[8*i +: 8] ^ cmp[8*i +: 8]) & msk[8*i +: 8]) == 8'h00;
  end

  assign gate = (clen == '0) ? (cnt != '0) : (cnt == clen);
  assign hit  = upd && gate && (&byte_ok);
endmodule

// File: rtl/irwake_status.sv
module irwake_status
  import irwake_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       set_match,
  input  logic       set_end,
  input  logic       set_full,
  input  logic       set_rpt,
  input  logic       clr_we,
  input  logic [7:0] clr_data,
  input  logic       ctl_en,
  input  logic [2:0] ev_en,
  output logic [7:0] sts_o,
  output logic       wake_o
);
  logic [7:0] sts_q;
  logic [7:0] set_v;
  logic [7:0] clr_v;

  assign set_v = {3'b000, set_rpt, 1'b0, set_full, set_end, set_match};
  assign clr_v = clr_we ? (clr_data & STS_MASK) : 8'h00;

  always_ff @(posedge clk) begin
    if (rst) begin
      sts_q  <= '0;
      wake_o <= 1'b0;
    end else begin
      sts_q  <= (sts_q & ~clr_v) | set_v;
      wake_o <= ctl_en && (|(sts_q[2:0] & ev_en));
    end
  end

  assign sts_o = sts_q;

  // R9: an event in the same cycle as its clear leaves the flag set
  a_r9_set_wins: assert property (@(posedge clk) disable iff (rst)
    set_match |=> sts_q[0]);

  // R9: a lone write of 1 clears the match flag
  a_r9_w1c: assert property (@(posedge clk) disable iff (rst)
    (clr_we && clr_data[0] && !set_match) |=> !sts_q[0]);

  // R11: wake never rises without the global enable
  a_r11_wake_gate: assert property (@(posedge clk) disable iff (rst)
    wake_o |-> $past(ctl_en));
endmodule

// File: rtl/irwake_matcher.sv
module irwake_matcher
  import irwake_pkg::*;
#(
  parameter int unsigned PAT_BYTES = 11,
  localparam int unsigned PAT_BITS = PAT_BYTES * 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       reg_we,
  input  logic [2:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       cell_valid,
  input  logic       cell_bit,
  input  logic       msg_start,
  input  logic       msg_end,
  input  logic       rpt_seen,
  output logic       wake
);
  logic                ctl_en;
  logic [2:0]          ev_en;
  logic [LEN_W-1:0]    clen;
  logic [PAT_BITS-1:0] cmp_bits;
  logic [PAT_BITS-1:0] msk_bits;
  logic [PAT_BITS-1:0] shreg;
  logic [LEN_W-1:0]    cnt;
  logic                upd;
  logic                full;
  logic                hit;
  logic [7:0]          sts;
  logic                clr_we;

  assign clr_we = reg_we && (reg_addr == RA_STAT);

  irwake_regfile #(.PAT_BYTES(PAT_BYTES)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .sts_i(sts), .rdata(reg_rdata), .ctl_en_o(ctl_en), .ev_en_o(ev_en),
    .clen_o(clen), .cmp_o(cmp_bits), .msk_o(msk_bits)
  );

  irwake_shifter #(.PAT_BITS(PAT_BITS)) u_shift (
    .clk(clk), .rst(rst), .cell_valid(cell_valid), .cell_bit(cell_bit),
    .msg_start(msg_start), .shreg_o(shreg), .cnt_o(cnt), .upd_o(upd), .full_o(full)
  );

  irwake_compare #(.PAT_BYTES(PAT_BYTES)) u_cmp (
    .shreg(shreg), .cmp(cmp_bits), .msk(msk_bits), .cnt(cnt), .clen(clen),
    .upd(upd), .hit(hit)
  );

  irwake_status u_sts (
    .clk(clk), .rst(rst), .set_match(hit), .set_end(msg_end), .set_full(full),
    .set_rpt(rpt_seen), .clr_we(clr_we), .clr_data(reg_wdata), .ctl_en(ctl_en),
    .ev_en(ev_en), .sts_o(sts), .wake_o(wake)
  );
endmodule

// File: tb/irwake_matcher_tb.sv
`timescale 1ns/1ps
module irwake_matcher_tb_top;
  localparam int PB = 11;
  localparam int PBITS = PB * 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       cell_valid = 1'b0;
  logic       cell_bit = 1'b0;
  logic       msg_start = 1'b0;
  logic       msg_end = 1'b0;
  logic       rpt_seen = 1'b0;
  logic       wake;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  bit [PBITS-1:0] m_cmp, m_msk, m_sh;
  int m_cnt = 0;
  int m_clen = 0;
  bit m_hit = 0;
  logic [7:0] rv;

  always #2 clk = ~clk;

  irwake_matcher #(.PAT_BYTES(PB)) dut_i (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .cell_valid(cell_valid), .cell_bit(cell_bit),
    .msg_start(msg_start), .msg_end(msg_end), .rpt_seen(rpt_seen), .wake(wake)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); reg_we = 1'b0; reg_addr = a;
    @(negedge clk); d = reg_rdata;
  endtask

  function automatic bit [7:0] manch4(input bit [3:0] nib);
    bit [7:0] c = '0;
    for (int i = 0; i < 4; i++) c[2*i +: 2] = nib[i] ? 2'b10 : 2'b01;
    return c;
  endfunction

  function automatic bit [39:0] frame40(input bit [15:0] w);
    return {8'h93, manch4(w[15:12]), manch4(w[11:8]), manch4(w[7:4]), manch4(w[3:0])};
  endfunction

  task automatic model_cell(input bit b);
    bit gate;
    m_sh = {m_sh[PBITS-2:0], b};
    if (m_cnt < 255) m_cnt++;
    gate = (m_clen == 0) ? (m_cnt != 0) : (m_cnt == m_clen);
    if (gate && ((m_sh ^ m_cmp) & m_msk) == '0) m_hit = 1;
  endtask

  task automatic send_cell(input bit b);
    @(negedge clk); cell_valid = 1'b1; cell_bit = b;
    @(negedge clk); cell_valid = 1'b0;
    model_cell(b);
  endtask

  task automatic start_msg();
    @(negedge clk); msg_start = 1'b1;
    @(negedge clk); msg_start = 1'b0;
    m_sh = '0; m_cnt = 0;
  endtask

  task automatic send_frame(input bit [PBITS-1:0] f, input int n);
    for (int i = n - 1; i >= 0; i--) send_cell(f[i]);
  endtask

  task automatic clear_sts();
    wr(3'd1, 8'h17); m_hit = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    bit [39:0] fr;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(3'd0, rv); chk("R1 control", rv, 8'h00);
    rd(3'd1, rv); chk("R1 status", rv, 8'h00);
    rd(3'd2, rv); chk("R1 event enable", rv, 8'h00);
    rd(3'd3, rv); chk("R1 index", rv, 8'h00);
    rd(3'd5, rv); chk("R1 compare length", rv, 8'h00);
    chk("R1 wake", wake, 1'b0);

    // R3 bank loading through the data port
    m_cmp = '0; m_msk = '0;
    m_cmp[39:0] = frame40(16'h1234);
    m_msk[39:0] = 40'hFF_3F_FF_FF_FF;
    wr(3'd3, 8'h10);
    for (int k = 0; k < PB; k++) wr(3'd4, m_cmp[8*k +: 8]);
    rd(3'd3, rv); chk("R3 index wraps to 0 after byte 10", rv, 8'h10);
    wr(3'd3, 8'h20);
    for (int k = 0; k < PB; k++) wr(3'd4, m_msk[8*k +: 8]);
    for (int k = 0; k < PB; k++) begin
      wr(3'd3, 8'h10 | 8'(k)); rd(3'd4, rv); chk("R3 reference byte readback", rv, m_cmp[8*k +: 8]);
      wr(3'd3, 8'h20 | 8'(k)); rd(3'd4, rv); chk("R3 mask byte readback", rv, m_msk[8*k +: 8]);
    end
    // R2 register offsets
    wr(3'd5, 8'd40); m_clen = 40;
    rd(3'd5, rv); chk("R2 compare length register", rv, 8'd40);
    wr(3'd2, 8'h01); rd(3'd2, rv); chk("R2 event enable register", rv, 8'h01);
    wr(3'd0, 8'h01); rd(3'd0, rv); chk("R2 control register", rv, 8'h01);

    // R4 writes with bank 00 are dropped, address advances
    wr(3'd3, 8'h02); wr(3'd4, 8'hAA);
    rd(3'd3, rv); chk("R4 address advanced", rv, 8'h03);
    wr(3'd3, 8'h32); wr(3'd4, 8'h55);
    wr(3'd3, 8'h12); rd(3'd4, rv); chk("R4 reference byte 2 kept", rv, m_cmp[23:16]);
    wr(3'd3, 8'h22); rd(3'd4, rv); chk("R4 mask byte 2 kept", rv, m_msk[23:16]);

    // R8 match timing and wake latency
    clear_sts(); start_msg();
    send_frame({48'h0, frame40(16'h1234)}, 40);
    chk("R8 wake low on accepting edge", wake, 1'b0);
    @(negedge clk); chk("R8 wake low while flag sets", wake, 1'b0);
    @(negedge clk); chk("R8 wake high one edge after flag", wake, 1'b1);
    rd(3'd1, rv); chk("R8 match flag set", rv[0], 1'b1);
    chk("R6 model agrees on exact frame", m_hit, 1'b1);

    // R6 sweep: flip each cell of the frame
    for (int p = 0; p < 40; p++) begin
      fr = frame40(16'h1234) ^ (40'd1 << p);
      clear_sts(); start_msg();
      send_frame({48'h0, fr}, 40);
      idle(2);
      rd(3'd1, rv); chk("R6 single-cell flip", rv[0], m_hit);
      chk("R6 only masked toggle cells tolerated", m_hit, (p == 30 || p == 31));
    end

    // R7 length gating sweep
    for (int j = 0; j < 4; j++) begin
      int c;
      c = (j == 0) ? 0 : 38 + j;
      wr(3'd5, 8'(c)); m_clen = c;
      clear_sts(); start_msg();
      send_frame({48'h0, frame40(16'h1234)}, 40);
      idle(2);
      rd(3'd1, rv); chk("R7 compare length gate", rv[0], m_hit);
    end
    wr(3'd5, 8'd40); m_clen = 40;
    clear_sts(); start_msg();
    for (int g = 0; g < 5; g++) send_cell(g[0]);
    send_frame({48'h0, frame40(16'h1234)}, 40);
    idle(2);
    rd(3'd1, rv); chk("R7 extra leading cells break exact length", rv[0], 1'b0);

    // R5 msg_start clears and beats a simultaneous cell
    clear_sts();
    for (int g = 0; g < 7; g++) send_cell(1'b1);
    @(negedge clk); msg_start = 1'b1; cell_valid = 1'b1; cell_bit = 1'b1;
    @(negedge clk); msg_start = 1'b0; cell_valid = 1'b0;
    m_sh = '0; m_cnt = 0;
    send_frame({48'h0, frame40(16'h1234)}, 40);
    idle(2);
    rd(3'd1, rv); chk("R5 start clears, simultaneous cell dropped", rv[0], 1'b1);

    // R9 write-1-to-clear and set priority
    wr(3'd1, 8'h00); rd(3'd1, rv); chk("R9 write 0 keeps flag", rv[0], 1'b1);
    wr(3'd1, 8'h01); rd(3'd1, rv); chk("R9 write 1 clears flag", rv[0], 1'b0);
    @(negedge clk); msg_end = 1'b1; reg_we = 1'b1; reg_addr = 3'd1; reg_wdata = 8'h02;
    @(negedge clk); msg_end = 1'b0; reg_we = 1'b0;
    rd(3'd1, rv); chk("R9 message-end set wins over clear", rv[1], 1'b1);
    @(negedge clk); rpt_seen = 1'b1; reg_we = 1'b1; reg_addr = 3'd1; reg_wdata = 8'h10;
    @(negedge clk); rpt_seen = 1'b0; reg_we = 1'b0;
    rd(3'd1, rv); chk("R9 repeat set wins over clear", rv[4], 1'b1);
    wr(3'd1, 8'h12); rd(3'd1, rv); chk("R9 lone clears empty register", rv, 8'h00);

    // R10 event sources
    start_msg();
    for (int g = 0; g < PBITS - 1; g++) send_cell(1'b0);
    idle(1);
    rd(3'd1, rv); chk("R10 no buffer-full at 87 cells", rv[2], 1'b0);
    send_cell(1'b0); idle(1);
    rd(3'd1, rv); chk("R10 buffer-full at 88 cells", rv[2], 1'b1);
    @(negedge clk); msg_end = 1'b1; @(negedge clk); msg_end = 1'b0;
    rd(3'd1, rv); chk("R10 message-end flag", rv[1], 1'b1);

    // R11 wake gating
    wr(3'd2, 8'h04); idle(2);
    chk("R11 wake on enabled buffer flag", wake, 1'b1);
    wr(3'd0, 8'h00); idle(2);
    chk("R11 no wake without global enable", wake, 1'b0);
    wr(3'd0, 8'h01); wr(3'd2, 8'h00); idle(2);
    chk("R11 no wake with events disabled", wake, 1'b0);
    wr(3'd1, 8'h17); wr(3'd2, 8'h07);
    @(negedge clk); rpt_seen = 1'b1; @(negedge clk); rpt_seen = 1'b0;
    idle(2);
    rd(3'd1, rv); chk("R10 repeat flag", rv, 8'h10);
    chk("R11 repeat flag never wakes", wake, 1'b0);

    summary();
  end
endmodule